// File: doc/BRIEF.md
# Channel interrupt status and mask unit

This block collects the interrupt sources of one transfer channel. Single-cycle event strobes from the channel datapath latch into twelve status bits. A mask decides which latched bits raise the single level interrupt line. Software reads the state and acknowledges it over a small 32-bit register bus that moves whole words only. The mask has no direct write. Software clears mask bits by writing to an enable port and sets them by writing to a disable port. Neither port stores the value written.

Two 8-bit accounting counters record descriptor completions, one for the source side and one for the destination side. A counter clears when software reads it. When a counter wraps from 255 to 0, the block latches an accounting error status bit. The interrupt output comes from a flop, so it follows the status and mask with one cycle of delay.

Word addresses on `bus_addr`: 0 status, 1 mask, 2 enable port, 3 disable port, 4 source count, 5 destination count. Addresses 6 and 7 are unmapped.

Status bit map, from bit 11 down to bit 0:

| Bit | Source |
|-----|--------|
| 11 | pause |
| 10 | done |
| 9 | write-data error |
| 8 | read-data error |
| 7 | destination descriptor read error |
| 6 | source descriptor read error |
| 5 | destination accounting error |
| 4 | source accounting error |
| 3 | byte-count overflow |
| 2 | destination descriptor done |
| 1 | source descriptor done |
| 0 | invalid access |

Top module: `chan_irq_unit`

## Requirements
- R1: After reset the status is 0, the mask is 0xFFF, both counters are 0, `irq` is 0 and `bus_rdata` is 0.
- R2: A 1 on bit i of `evt_set` sets status bit i at the next clock edge. The status bit map is the one given in the table above.
- R3: A bus write to address 0 clears each status bit whose `bus_wdata` bit is 1 and leaves the other status bits unchanged. If an event sets a bit in the same cycle that the write clears it, the bit ends up set. Status bits 31..12 always read as 0.
- R4: The mask, read at address 1, is read-only. Bus writes to address 1 have no effect, and bus writes to addresses 4 and 5 have no effect on the counters.
- R5: A bus write to address 2 clears each mask bit whose `bus_wdata` bit is 1. Address 2 always reads as 0.
- R6: A bus write to address 3 sets each mask bit whose `bus_wdata[11:0]` bit is 1. Address 3 always reads as 0.
- R7: In the cycle after any status bit is 1 while its mask bit is 0, `irq` is 1. In every other cycle `irq` is 0.
- R8: A pulse on `src_cmpl` increments the source count and sets status bit 1. A pulse on `dst_cmpl` increments the destination count and sets status bit 2.
- R9: An increment from 255 gives 0. A source wrap sets status bit 4, and a destination wrap sets status bit 5.
- R10: A read of address 4 or address 5 returns the count and clears it. If an increment falls in the same cycle as that read, the read returns the old value, the count becomes 1, and no wrap error is raised.
- R11: `bus_rdata` shows the value of the read register from the clock edge that samples `bus_rd` and holds it until the next read. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe for the word at `bus_addr` |
| bus_wr | input | 1 | Write strobe for the word at `bus_addr` |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_set | input | 12 | Event strobes, one per status bit |
| src_cmpl | input | 1 | Source descriptor completion strobe |
| dst_cmpl | input | 1 | Destination descriptor completion strobe |
| irq | output | 1 | Level interrupt |

## Verification
Two functions of this block can fall in the same cycle.

The first collision pits acknowledge against a new event. A write-1-to-clear of a status bit lands in the same cycle as an event that sets that bit. The bench forces this by writing 1 to bit 1 of the status while pulsing `src_cmpl`. It then expects bit 1 to read back as set.

The second collision pits clear-on-read against a new completion. A read of a count coincides with an increment of that count. The bench expects the read to return the old value and the following read to return 1.

Random traffic mixes both collisions with the other bus operations. Every result is judged against a cycle model of the bench's own.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int NSRC   = 12;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  // Status bit positions (software decodes these)
  localparam int B_INVAL    = 0;
  localparam int B_SRC_DONE = 1;
  localparam int B_DST_DONE = 2;
  localparam int B_SRC_ACCT = 4;
  localparam int B_DST_ACCT = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 3'd0,
    A_MASK = 3'd1,
    A_UNMK = 3'd2,
    A_SETM = 3'd3,
    A_SCNT = 3'd4,
    A_DCNT = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] st_q
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)          st_q[i] <= 1'b0;
        else if (set_i[i])   st_q[i] <= 1'b1;
        else if (clr_i[i])   st_q[i] <= 1'b0;
      end

      p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> st_q[i]);
      p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[i] && !set_i[i]) |=> !st_q[i]);
      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i[i] && !set_i[i]) |=> $stable(st_q[i]));
    end
  endgenerate
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         unmask_wr,
  input  logic         mask_wr,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         mask_q <= {N{1'b1}};
    else if (unmask_wr) mask_q <= mask_q & ~bits_i;
    else if (mask_wr)   mask_q <= mask_q | bits_i;
  end

  p_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_wr |=> (mask_q & $past(bits_i)) == '0);
  p_setmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !unmask_wr) |=> (mask_q & $past(bits_i)) == $past(bits_i));
  p_mask_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unmask_wr && !mask_wr) |=> $stable(mask_q));
endmodule

// File: rtl/acct_counter.sv
module acct_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_q,
  output logic         wrap_o
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  // {wrap, next}: a clear drops the old count, then the increment applies
  function automatic logic [W:0] acct_step(logic [W-1:0] c, logic inc, logic clr);
    logic [W-1:0] base;
    base = clr ? '0 : c;
    return {inc && (base == CMAX), base + {{(W-1){1'b0}}, inc}};
  endfunction

  logic [W:0] step;
  assign step   = acct_step(cnt_q, inc_i, clr_i);
  assign wrap_o = step[W];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= step[W-1:0];
  end

  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && cnt_q == CMAX) |=> cnt_q == '0);
  p_cor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !inc_i) |=> cnt_q == '0);
  p_cor_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && inc_i) |=> cnt_q == {{(W-1){1'b0}}, 1'b1});
  p_incr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && cnt_q != CMAX) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/chan_irq_unit.sv
module chan_irq_unit
  import chan_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   evt_set,
  input  logic              src_cmpl,
  input  logic              dst_cmpl,
  output logic              irq
);
  logic [NSRC-1:0]  st_q, mk_q, set_vec, clr_vec, pend;
  logic [CNT_W-1:0] scnt, dcnt;
  logic             src_wrap, dst_wrap;
  logic             wr_stat, wr_unmk, wr_setm, rd_scnt, rd_dcnt;
  logic             irq_q;
  logic [DATA_W-1:0] rdata_q;

  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_unmk = bus_wr && (bus_addr == A_UNMK);
  assign wr_setm = bus_wr && (bus_addr == A_SETM);
  assign rd_scnt = bus_rd && (bus_addr == A_SCNT);
  assign rd_dcnt = bus_rd && (bus_addr == A_DCNT);

  assign clr_vec = wr_stat ? bus_wdata[NSRC-1:0] : '0;

  always_comb begin
    set_vec             = evt_set;
    set_vec[B_SRC_DONE] = evt_set[B_SRC_DONE] | src_cmpl;
    set_vec[B_DST_DONE] = evt_set[B_DST_DONE] | dst_cmpl;
    set_vec[B_SRC_ACCT] = evt_set[B_SRC_ACCT] | src_wrap;
    set_vec[B_DST_ACCT] = evt_set[B_DST_ACCT] | dst_wrap;
  end

  irq_status_bits #(.N(NSRC)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .st_q(st_q));

  irq_mask_reg #(.N(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .unmask_wr(wr_unmk), .mask_wr(wr_setm),
    .bits_i(bus_wdata[NSRC-1:0]), .mask_q(mk_q));

  acct_counter #(.W(CNT_W)) u_src_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(src_cmpl), .clr_i(rd_scnt),
    .cnt_q(scnt), .wrap_o(src_wrap));

  acct_counter #(.W(CNT_W)) u_dst_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(dst_cmpl), .clr_i(rd_dcnt),
    .cnt_q(dcnt), .wrap_o(dst_wrap));

  function automatic logic [DATA_W-1:0] read_mux(
    logic [ADDR_W-1:0] a, logic [NSRC-1:0] st, logic [NSRC-1:0] mk,
    logic [CNT_W-1:0] sc, logic [CNT_W-1:0] dc);
    logic [DATA_W-1:0] v;
    v = '0;
    case (a)
      A_STAT:  v[NSRC-1:0]  = st;
      A_MASK:  v[NSRC-1:0]  = mk;
      A_SCNT:  v[CNT_W-1:0] = sc;
      A_DCNT:  v[CNT_W-1:0] = dc;
      default: v = '0;
    endcase
    return v;
  endfunction

  assign pend = st_q & ~mk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      irq_q <= |pend;
      if (bus_rd) rdata_q <= read_mux(bus_addr, st_q, mk_q, scnt, dcnt);
    end
  end

  assign irq       = irq_q;
  assign bus_rdata = rdata_q;

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == '0) |=> !irq);
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_q == {NSRC{1'b1}}) |=> !irq);
  p_src_wrap_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    src_wrap |=> st_q[B_SRC_ACCT]);
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/chan_irq_unit_tb.sv
module chan_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] evt_set = '0;
  logic        src_cmpl = 1'b0, dst_cmpl = 1'b0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [11:0] m_st, m_mk;
  logic [7:0]  m_cs, m_cd;
  logic        m_irq;
  logic [31:0] m_rd;

  always #2 clk = ~clk;

  chan_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .src_cmpl(src_cmpl), .dst_cmpl(dst_cmpl), .irq(irq));

  function automatic logic [31:0] mdl_read(logic [2:0] a);
    case (a)
      3'd0: return {20'd0, m_st};
      3'd1: return {20'd0, m_mk};
      3'd4: return {24'd0, m_cs};
      3'd5: return {24'd0, m_cd};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4, 3'd5: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic mdl_reset();
    m_st = '0; m_mk = 12'hFFF; m_cs = '0; m_cd = '0; m_irq = 0; m_rd = '0;
  endtask

  // Advance the model by one clock using the inputs now applied
  task automatic mdl_step();
    logic [11:0] st_n, mk_n, clr;
    logic        cs_clr, cd_clr, s_wrap, d_wrap;
    logic [7:0]  cs_b, cd_b;
    m_irq = |(m_st & ~m_mk);
    if (bus_rd) m_rd = mdl_read(bus_addr);
    cs_clr = bus_rd && bus_addr == 3'd4;
    cd_clr = bus_rd && bus_addr == 3'd5;
    cs_b = cs_clr ? 8'd0 : m_cs;
    cd_b = cd_clr ? 8'd0 : m_cd;
    s_wrap = src_cmpl && cs_b == 8'd255;
    d_wrap = dst_cmpl && cd_b == 8'd255;
    clr = (bus_wr && bus_addr == 3'd0) ? bus_wdata[11:0] : 12'd0;
    st_n = (m_st & ~clr) | evt_set;
    if (src_cmpl) st_n[1] = 1'b1;
    if (dst_cmpl) st_n[2] = 1'b1;
    if (s_wrap)   st_n[4] = 1'b1;
    if (d_wrap)   st_n[5] = 1'b1;
    mk_n = m_mk;
    if (bus_wr && bus_addr == 3'd2) mk_n = m_mk & ~bus_wdata[11:0];
    if (bus_wr && bus_addr == 3'd3) mk_n = m_mk | bus_wdata[11:0];
    m_st = st_n; m_mk = mk_n;
    m_cs = cs_b + {7'd0, src_cmpl};
    m_cd = cd_b + {7'd0, dst_cmpl};
  endtask

  // One bus/event cycle; inputs applied at negedge, checked at next negedge
  task automatic cyc(logic rd, logic wr, logic [2:0] a, logic [31:0] wd,
                     logic [11:0] ev, logic sc, logic dc, string rtag);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    evt_set = ev; src_cmpl = sc; dst_cmpl = dc;
    @(posedge clk);
    mdl_step();
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; evt_set = '0; src_cmpl = 0; dst_cmpl = 0;
    chk("R7", {31'd0, irq}, {31'd0, m_irq});
    if (rd) chk(rtag, bus_rdata, m_rd);
  endtask

  task automatic rd_chk(logic [2:0] a, string t);
    cyc(1, 0, a, 0, 0, 0, 0, t);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, "");
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", {31'd0, irq}, 32'd0);
    chk("R1", bus_rdata, 32'd0);
    rd_chk(3'd0, "R1");
    rd_chk(3'd1, "R1");
    rd_chk(3'd4, "R1");
    rd_chk(3'd5, "R1");

    // R2 event sets bit; R7 irq only after unmask
    cyc(0, 0, 0, 0, 12'h800, 0, 0, "");
    rd_chk(3'd0, "R2");
    cyc(0, 1, 3'd2, 32'h800, 0, 0, 0, "");
    idle();
    chk("R7", {31'd0, irq}, 32'd1);
    rd_chk(3'd2, "R5");
    rd_chk(3'd1, "R5");
    // R4 writes to mask and counters ignored
    cyc(0, 1, 3'd1, 32'hFFFF_FFFF, 0, 0, 0, "");
    cyc(0, 1, 3'd4, 32'h55, 0, 0, 0, "");
    rd_chk(3'd1, "R4");
    rd_chk(3'd4, "R4");
    // R6 disable sets mask bits
    cyc(0, 1, 3'd3, 32'hFFFF_F800, 0, 0, 0, "");
    idle();
    chk("R6", {31'd0, irq}, 32'd0);
    rd_chk(3'd3, "R6");
    // R3 W1C, upper bits zero
    cyc(0, 1, 3'd0, 32'hFFFF_FFFF, 0, 0, 0, "");
    rd_chk(3'd0, "R3");
    // R8 completions
    cyc(0, 0, 0, 0, 0, 1, 1, "");
    cyc(0, 0, 0, 0, 0, 1, 0, "");
    rd_chk(3'd0, "R8");
    rd_chk(3'd4, "R8");
    rd_chk(3'd5, "R8");
    rd_chk(3'd4, "R10");
    // R3 set wins over W1C
    cyc(0, 1, 3'd0, 32'h2, 0, 1, 0, "");
    rd_chk(3'd0, "R3");
    chk("R3", bus_rdata & 32'h2, 32'h2);
    // R10 read and increment collide
    cyc(0, 0, 0, 0, 0, 0, 1, "");
    cyc(1, 0, 3'd5, 0, 0, 0, 1, "R10");
    rd_chk(3'd5, "R10");
    chk("R10", bus_rdata, 32'd1);
    // R9 wrap
    cyc(0, 1, 3'd0, 32'hFFF, 0, 0, 0, "");
    for (int k = 0; k < 256; k++) cyc(0, 0, 0, 0, 0, 1, 1, "");
    rd_chk(3'd0, "R9");
    chk("R9", bus_rdata & 32'h36, 32'h36);
    rd_chk(3'd4, "R9");
    // R11 unmapped and hold
    rd_chk(3'd6, "R11");
    rd_chk(3'd7, "R11");
    idle();
    chk("R11", bus_rdata, 32'd0);

    // Random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [2:0]  a;
      logic [31:0] wd;
      logic [11:0] ev;
      int op;
      a  = 3'($urandom_range(0, 7));
      wd = $urandom;
      ev = ($urandom_range(0, 5) == 0) ? 12'(1 << $urandom_range(0, 11)) : 12'd0;
      op = $urandom_range(0, 3);
      cyc(op == 1, op == 2, a, wd, ev,
          $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, tag_of(a));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule